// File: doc/BRIEF.md
# Receive Idle Time-out Counter

This block is a shared down-counter that watches the receive streams of one or more serial channels. It tells software that incoming data has stopped. Each channel reports a one-cycle strobe every time a finished character is pushed into its receive queue. While time-out mode is armed for a channel, each such strobe restarts the counter from a 16-bit reload value. If the counter runs down before the next strobe arrives, a sticky ready flag is raised. The flag can be masked onto an interrupt line.

The counter advances only on cycles where the counter-clock enable is high. A restart takes one counter-clock to load the reload value, which is given as an upper and a lower byte, and counting starts on the counter-clock after that. Software controls the block through per-channel command writes. An arm command turns the mode on for that channel, clears the flag and parks the counter until a character arrives. A disarm command turns the mode off for that channel. The counter is shared, so with several channels armed it expires only after all of them have been silent for the whole interval.

Top module: `rx_idle_timeout`

## Requirements
- R1: A strobe from an armed channel stops the counter. The next counter-clock loads `{reload_hi, reload_lo}` without counting, and the following counter-clocks decrement. With reload value V, `ctr_ready` rises on the (max(V,1)+1)-th counter-clock after the strobe.
- R2: When the count reaches zero, `ctr_ready` is set. The counter then holds at zero without wrapping, and the flag stays set through further counter-clocks.
- R3: `irq` is high exactly when `ctr_ready` is high and `irq_mask` is high.
- R4: A strobe from an armed channel while `ctr_ready` is set clears `ctr_ready` (and so `irq`) in the next cycle and starts a new restart sequence.
- R5: A command write whose code has upper nibble 0xA arms that channel. It clears `ctr_ready` and parks the counter, so no counter-clock has any effect until the next strobe.
- R6: A command write whose code has upper nibble 0xC disarms that channel. Strobes from a disarmed channel are ignored. When no channel is left armed, the counter parks and `ctr_ready` keeps its value.
- R7: A command write with any other upper nibble, including ordinary start or stop codes, has no effect.
- R8: With several channels armed, a strobe from any of them restarts the shared counter. The flag rises only after the full interval has passed with no strobe from any armed channel.
- R9: The reload value is sampled on the loading counter-clock. A change to the reload bytes after that point takes effect only at the next restart.
- R10: When an arm command and a strobe fall in the same cycle, the arm command wins: the flag is cleared and the counter stays parked.
- R11: After reset, `ctr_ready` and `irq` are low and every channel is disarmed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Counter-clock enable, one cycle per counter step |
| reload_hi | input | 8 | Upper byte of the reload value |
| reload_lo | input | 8 | Lower byte of the reload value |
| char_xfer | input | NUM_CH | Per-channel strobe: a character entered the receive queue |
| cmd_wr | input | NUM_CH | Per-channel command write strobe |
| cmd_code | input | 8 | Command code; upper nibble 0xA arms, 0xC disarms |
| irq_mask | input | 1 | Interrupt mask for the ready flag |
| ctr_ready | output | 1 | Sticky counter-ready flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the single parked counter-clock in the restart sequence. A design that counts on the loading step would raise the flag one counter-clock early. It also checks that the counter stays at zero after expiry: a design that wraps would drop the flag or raise it again later. Reload bytes are changed right after the load to catch a design that reads them live, and arm commands are placed in the same cycle as strobes to catch a design with the wrong precedence. Staggered strobes on two channels show whether a design keeps separate per-channel timers in place of one shared counter.

// File: rtl/rxto_pkg.sv
package rxto_pkg;
  typedef enum logic [1:0] {
    PH_PARK = 2'd0,
    PH_LOAD = 2'd1,
    PH_RUN  = 2'd2,
    PH_DONE = 2'd3
  } rxto_phase_e;

  localparam logic [3:0] OP_ARM    = 4'hA;
  localparam logic [3:0] OP_DISARM = 4'hC;
endpackage

// File: rtl/rxto_rst_sync.sv
module rxto_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/rxto_cmd_ctrl.sv
module rxto_cmd_ctrl
  import rxto_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] cmd_wr,
  input  logic [7:0]        cmd_code,
  output logic [NUM_CH-1:0] arm_en_q,
  output logic [NUM_CH-1:0] arm_en_d,
  output logic              arm_pulse
);
  logic is_arm;
  logic is_disarm;

  assign is_arm    = (cmd_code[7:4] == OP_ARM);
  assign is_disarm = (cmd_code[7:4] == OP_DISARM);
  assign arm_pulse = is_arm && (|cmd_wr);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_comb begin
      arm_en_d[ch] = arm_en_q[ch];
      if (cmd_wr[ch] && is_arm)         arm_en_d[ch] = 1'b1;
      else if (cmd_wr[ch] && is_disarm) arm_en_d[ch] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_en_q[ch] <= 1'b0;
      else        arm_en_q[ch] <= arm_en_d[ch];
    end
  end
endmodule

// File: rtl/rxto_counter.sv
module rxto_counter
  import rxto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             arm,
  input  logic             restart,
  input  logic             any_armed,
  input  logic [CNT_W-1:0] reload,
  output logic             ready,
  output logic [CNT_W-1:0] count,
  output rxto_phase_e      phase
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  rxto_phase_e      phase_d;
  logic [CNT_W-1:0] cnt_d;
  logic             rdy_d;

  always_comb begin
    phase_d = phase;
    cnt_d   = count;
    rdy_d   = ready;
    if (arm) begin
      phase_d = PH_PARK;
      rdy_d   = 1'b0;
    end else if (restart) begin
      phase_d = PH_LOAD;
      rdy_d   = 1'b0;
    end else if (tick) begin
      case (phase)
        PH_LOAD: begin
          cnt_d   = reload;
          phase_d = PH_RUN;
        end
        PH_RUN: begin
          if (count <= ONE) begin
            cnt_d   = '0;
            rdy_d   = 1'b1;
            phase_d = PH_DONE;
          end else begin
            cnt_d = count - ONE;
          end
        end
        default: ;
      endcase
    end
    if (!any_armed) phase_d = PH_PARK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_PARK;
      count <= '0;
      ready <= 1'b0;
    end else begin
      phase <= phase_d;
      count <= cnt_d;
      ready <= rdy_d;
    end
  end
endmodule

// File: rtl/rx_idle_timeout.sv
module rx_idle_timeout
  import rxto_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [BYTE_W-1:0] reload_hi,
  input  logic [BYTE_W-1:0] reload_lo,
  input  logic [NUM_CH-1:0] char_xfer,
  input  logic [NUM_CH-1:0] cmd_wr,
  input  logic [7:0]        cmd_code,
  input  logic              irq_mask,
  output logic              ctr_ready,
  output logic              irq
);
  localparam int CNT_W = 2 * BYTE_W;

  logic              rst_n_int;
  logic [NUM_CH-1:0] armed_q;
  logic [NUM_CH-1:0] armed_d;
  logic              arm_w;
  logic              restart_w;
  logic [CNT_W-1:0]  count_w;
  rxto_phase_e       phase_w;

  rxto_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  rxto_cmd_ctrl #(.NUM_CH(NUM_CH)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cmd_wr    (cmd_wr),
    .cmd_code  (cmd_code),
    .arm_en_q  (armed_q),
    .arm_en_d  (armed_d),
    .arm_pulse (arm_w)
  );

  assign restart_w = |(char_xfer & armed_q);

  rxto_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .tick      (tick),
    .arm       (arm_w),
    .restart   (restart_w),
    .any_armed (|armed_d),
    .reload    ({reload_hi, reload_lo}),
    .ready     (ctr_ready),
    .count     (count_w),
    .phase     (phase_w)
  );

  assign irq = ctr_ready & irq_mask;
endmodule

// File: rtl/rxto_checker.sv
module rxto_checker
  import rxto_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic             irq_mask,
  input logic             irq,
  input logic             ready,
  input logic             arm,
  input logic             restart,
  input logic [CNT_W-1:0] count,
  input rxto_phase_e      phase
);
  // R3
  a_r3_irq_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ready && irq_mask));

  // R4
  a_r4_char_clears_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (restart && !arm) |=> (!ready && phase == PH_LOAD));

  // R5 and R10
  a_r5_arm_parks: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!ready && phase == PH_PARK));

  // R2
  a_r2_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !arm && !restart) |=> ready);

  // R2
  a_r2_zero_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (count == '0));

  // R1
  a_r1_load_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_LOAD && !tick) |=> $stable(count));

  // R2
  a_r2_rise_from_run: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> ($past(phase) == PH_RUN && $past(tick)));
endmodule

bind rx_idle_timeout rxto_checker #(.CNT_W(2 * BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .irq_mask (irq_mask),
  .irq      (irq),
  .ready    (ctr_ready),
  .arm      (arm_w),
  .restart  (restart_w),
  .count    (count_w),
  .phase    (phase_w)
);

// File: tb/rx_idle_timeout_test.sv
module rx_idle_timeout_test;
  localparam int NCH = 2;

  logic           clk;
  logic           rst_n;
  logic           tick;
  logic [7:0]     reload_hi;
  logic [7:0]     reload_lo;
  logic [NCH-1:0] char_xfer;
  logic [NCH-1:0] cmd_wr;
  logic [7:0]     cmd_code;
  logic           irq_mask;
  logic           ctr_ready;
  logic           irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  string phase_tag = "R11";

  rx_idle_timeout #(.NUM_CH(NCH), .BYTE_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .reload_hi(reload_hi), .reload_lo(reload_lo),
    .char_xfer(char_xfer), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .irq_mask(irq_mask), .ctr_ready(ctr_ready), .irq(irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // behavioural reference, written from the requirements
  bit [NCH-1:0] m_arm;
  int           m_state;   // 0 parked, 1 waiting to load, 2 counting, 3 expired
  int           m_cnt;
  bit           m_rdy;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_arm = '0; m_state = 0; m_cnt = 0; m_rdy = 0;
    end else begin
      bit [NCH-1:0] nxt;
      bit got_arm;
      nxt = m_arm;
      got_arm = 0;
      for (int c = 0; c < NCH; c++) begin
        if (cmd_wr[c] && cmd_code[7:4] == 4'hA) begin nxt[c] = 1; got_arm = 1; end
        else if (cmd_wr[c] && cmd_code[7:4] == 4'hC) nxt[c] = 0;
      end
      if (got_arm) begin
        m_state = 0; m_rdy = 0;
      end else if ((char_xfer & m_arm) != 0) begin
        m_state = 1; m_rdy = 0;
      end else if (tick) begin
        if (m_state == 1) begin
          m_cnt = {reload_hi, reload_lo}; m_state = 2;
        end else if (m_state == 2) begin
          if (m_cnt <= 1) begin m_cnt = 0; m_rdy = 1; m_state = 3; end
          else m_cnt = m_cnt - 1;
        end
      end
      if (nxt == 0) m_state = 0;
      m_arm = nxt;
    end
  end

  task automatic check(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n && !finished) begin
      check(ctr_ready, m_rdy, {phase_tag, " flag vs model (R2)"});
      check(irq, m_rdy & irq_mask, {phase_tag, " irq vs model (R3)"});
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; @(negedge clk);
    end
  endtask

  task automatic strobe(input bit [NCH-1:0] ch);
    char_xfer = ch; @(negedge clk);
    char_xfer = '0;
  endtask

  task automatic command(input bit [NCH-1:0] ch, input bit [7:0] code);
    cmd_wr = ch; cmd_code = code; @(negedge clk);
    cmd_wr = '0; cmd_code = 8'h00;
  endtask

  task automatic set_reload(input int v);
    reload_hi = 8'(v >> 8); reload_lo = 8'(v);
  endtask

  initial begin
    rst_n = 1'b0; tick = 0; char_xfer = '0; cmd_wr = '0; cmd_code = 8'h00;
    irq_mask = 1'b1; set_reload(3);
    idle(3);
    phase_tag = "R11";
    check(ctr_ready, 0, "R11 flag in reset");
    check(irq, 0, "R11 irq in reset");
    @(posedge clk); #1 rst_n = 1'b1;
    idle(5);
    check(ctr_ready, 0, "R11 flag after reset");

    phase_tag = "R5";
    command(2'b01, 8'hA0);
    ticks(10);
    check(ctr_ready, 0, "R5 parked until first character");

    phase_tag = "R1";
    strobe(2'b01);
    ticks(3);
    check(ctr_ready, 0, "R1 not expired after load plus two steps");
    ticks(1);
    check(ctr_ready, 1, "R1 expires on fourth counter-clock for reload 3");
    check(irq, 1, "R3 irq with mask set");
    phase_tag = "R2";
    ticks(6);
    check(ctr_ready, 1, "R2 flag held, no wrap");
    irq_mask = 1'b0; idle(1);
    check(irq, 0, "R3 irq masked");
    irq_mask = 1'b1; idle(1);

    phase_tag = "R4";
    strobe(2'b01);
    check(ctr_ready, 0, "R4 character clears flag");
    check(irq, 0, "R4 character withdraws irq");
    ticks(4);
    check(ctr_ready, 1, "R4 restarted count expires again");

    phase_tag = "R9";
    strobe(2'b01);
    set_reload(5);
    ticks(1);
    set_reload(1);
    ticks(4);
    check(ctr_ready, 0, "R9 late reload write ignored");
    ticks(1);
    check(ctr_ready, 1, "R9 sampled reload 5 used");

    phase_tag = "R7";
    command(2'b01, 8'h80);
    command(2'b01, 8'h90);
    idle(1);
    check(ctr_ready, 1, "R7 other command codes have no effect");

    phase_tag = "R5";
    command(2'b01, 8'hA0);
    check(ctr_ready, 0, "R5 arm clears flag");
    ticks(10);
    check(ctr_ready, 0, "R5 counter parked after arm");

    phase_tag = "R6";
    strobe(2'b10);
    ticks(10);
    check(ctr_ready, 0, "R6 strobe from disarmed channel ignored");

    phase_tag = "R8";
    set_reload(4);
    command(2'b10, 8'hA2);
    strobe(2'b01);
    ticks(3);
    strobe(2'b10);
    ticks(4);
    check(ctr_ready, 0, "R8 second channel restarted shared count");
    ticks(1);
    check(ctr_ready, 1, "R8 expiry after both channels silent");

    phase_tag = "R10";
    cmd_wr = 2'b01; cmd_code = 8'hA0; char_xfer = 2'b01; @(negedge clk);
    cmd_wr = '0; cmd_code = 8'h00; char_xfer = '0;
    check(ctr_ready, 0, "R10 arm clears flag");
    ticks(10);
    check(ctr_ready, 0, "R10 arm wins over same-cycle strobe");

    phase_tag = "R6";
    strobe(2'b01);
    ticks(5);
    check(ctr_ready, 1, "R6 expired before disarm");
    command(2'b11, 8'hC0);
    ticks(3);
    check(ctr_ready, 1, "R6 flag kept after last disarm");
    strobe(2'b01);
    idle(1);
    check(ctr_ready, 1, "R6 strobe after disarm ignored");

    phase_tag = "R1";
    set_reload(0);
    command(2'b01, 8'hA0);
    strobe(2'b01);
    ticks(1);
    check(ctr_ready, 0, "R1 zero reload: load step does not expire");
    ticks(1);
    check(ctr_ready, 1, "R1 zero reload expires on second counter-clock");

    phase_tag = "RND R1 R4 R5 R6 R8";
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      tick = ($urandom_range(0, 2) != 0);
      char_xfer = (r < 6) ? NCH'($urandom_range(1, 3)) : '0;
      if (r >= 97) begin
        cmd_wr = NCH'($urandom_range(1, 3));
        case ($urandom_range(0, 2))
          0: cmd_code = 8'hA1;
          1: cmd_code = 8'hC3;
          default: cmd_code = 8'h5F;
        endcase
      end else begin
        cmd_wr = '0; cmd_code = 8'h00;
      end
      if (r == 50) irq_mask = ~irq_mask;
      if (r == 51) set_reload($urandom_range(0, 12));
      @(negedge clk);
    end
    tick = 0; char_xfer = '0; cmd_wr = '0;
    idle(2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule